// File: doc/BRIEF.md
# Strap-Latched Clock Configuration Controller

This block holds the digital configuration and production-test logic of a multi-output clock generator. Four board pins are shared between two jobs. While power-on reset is held they are inputs, and a pull resistor on each sets its level. On the reference clock edge where reset is first seen released, those levels are captured into a 4-bit configuration register. From then on the same pins are driven as clock outputs.

The captured bits form a 3-bit frequency select code and a bus timing select, both reported on ports for the external frequency synthesizer. One select code puts the block into a production test mode. In that mode integer dividers derive the fixed-rate and bus clocks directly from the reference. Outside that mode the divided outputs stay low.

Top module: `strap_clk_cfg`

## Requirements
- R1: While `por_n` is sampled low, `strap_oe` is 0000, `strap_out` is 0000 and `test_mode`, `usb_clk`, `fd_clk` and `bus_clk` are all 0.
- R2: At the first rising edge of `clk_ref` with `por_n` high, `strap_in` is captured. Bit 0 is the bus select and appears on `bus_sync`. Bits 1, 2 and 3 are select bits 0, 1 and 2 and appear on `fsel[0]`, `fsel[1]` and `fsel[2]`.
- R3: Changes on `strap_in` after the capture edge leave `fsel` and `bus_sync` unchanged until the next power-on reset.
- R4: From the capture edge on, `strap_oe` is 1111. `strap_out[0]` carries `clk_ref` and `strap_out[3:1]` each carry `cpu_clk_in`.
- R5: `test_mode` is 1 from the capture edge exactly when the captured `fsel` equals 3'b011.
- R6: In test mode, `usb_clk` is the reference divided by 2. Counting the capture edge as edge 0, it is high after edge k when k is odd.
- R7: In test mode, `fd_clk` is the reference divided by 4. It is high after edge k when k mod 4 is 2 or 3.
- R8: In test mode with `bus_sync` = 1, `bus_clk` is the reference divided by 4, in phase with `fd_clk`.
- R9: In test mode with `bus_sync` = 0, `bus_clk` is the reference divided by 3. It is high after edge k exactly when k mod 3 is 2.
- R10: Outside test mode, `usb_clk`, `fd_clk` and `bus_clk` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, sampled on clk_ref |
| strap_in | input | 4 | Levels seen on the shared pins |
| cpu_clk_in | input | 1 | Synthesized processor clock routed to shared pins 3:1 |
| strap_out | output | 4 | Clock values driven onto the shared pins |
| strap_oe | output | 4 | Output enables of the shared pins |
| fsel | output | 3 | Captured frequency select code |
| bus_sync | output | 1 | Captured bus select (1 = synchronous) |
| test_mode | output | 1 | Production test mode active |
| usb_clk | output | 1 | Fixed-rate output, reference / 2 in test mode |
| fd_clk | output | 1 | Fixed-rate output, reference / 4 in test mode |
| bus_clk | output | 1 | Bus clock, reference / 4 or / 3 in test mode |

## Verification
The assertions assume that `por_n` is low from time zero and changes only away from the `clk_ref` rising edge. They also assume that `strap_in` is steady at the edge that ends reset. The bench changes `por_n` and `strap_in` only on falling edges. It sweeps all sixteen strap codes, and for each one it then flips every strap bit after capture so that any late sampling would show on `fsel` or `bus_sync`. The divider phases are checked over twelve edges after each capture, which spans the full periods of 2, 3 and 4.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
    parameter int STRAP_W = 4;
    localparam int FS_W = STRAP_W - 1;

    typedef struct packed {
        logic [FS_W-1:0] fs;
        logic            bsel;
    } cfg_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_cfg_pkg::*;
#(
    parameter logic [FS_W-1:0] TEST_CODE = 3'b011
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] pins,
    output cfg_t               cfg,
    output logic               active,
    output logic               test
);
    typedef struct packed {
        cfg_t cfg;
        logic active;
        logic test;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            st_d.cfg    = cfg_t'(pins);
            st_d.active = 1'b1;
            st_d.test   = (pins[STRAP_W-1:1] == TEST_CODE);
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg    = st_q.cfg;
    assign active = st_q.active;
    assign test   = st_q.test;
endmodule

// File: rtl/test_divider.sv
module test_divider #(
    parameter int QUAD_W = 2,
    parameter int RING_N = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic half,
    output logic quarter,
    output logic third
);
    typedef struct packed {
        logic [QUAD_W-1:0] quad;
        logic [RING_N-1:0] ring;
    } div_t;

    localparam logic [RING_N-1:0] RING_INIT = {{(RING_N-1){1'b0}}, 1'b1};

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.quad = st_q.quad + 1'b1;
            st_d.ring = {st_q.ring[RING_N-2:0], st_q.ring[RING_N-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.quad <= '0;
            st_q.ring <= RING_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign half    = st_q.quad[0];
    assign quarter = st_q.quad[QUAD_W-1];
    assign third   = st_q.ring[RING_N-1];
endmodule

// File: rtl/strap_clk_cfg.sv
module strap_clk_cfg
    import strap_cfg_pkg::*;
#(
    parameter logic [2:0] TEST_CODE = 3'b011
) (
    input  logic                clk_ref,
    input  logic                por_n,
    input  logic [3:0]          strap_in,
    input  logic                cpu_clk_in,
    output logic [3:0]          strap_out,
    output logic [3:0]          strap_oe,
    output logic [2:0]          fsel,
    output logic                bus_sync,
    output logic                test_mode,
    output logic                usb_clk,
    output logic                fd_clk,
    output logic                bus_clk
);
    cfg_t cfg;
    logic active, test, half, quarter, third;

    strap_capture #(.TEST_CODE(TEST_CODE)) u_cap (
        .clk    (clk_ref),
        .por_n  (por_n),
        .pins   (strap_in),
        .cfg    (cfg),
        .active (active),
        .test   (test)
    );

    test_divider u_div (
        .clk     (clk_ref),
        .por_n   (por_n),
        .run     (test),
        .half    (half),
        .quarter (quarter),
        .third   (third)
    );

    assign strap_oe  = {STRAP_W{active}};
    assign strap_out = {{FS_W{cpu_clk_in & active}}, clk_ref & active};
    assign fsel      = cfg.fs;
    assign bus_sync  = cfg.bsel;
    assign test_mode = test;
    assign usb_clk   = half;
    assign fd_clk    = quarter;
    assign bus_clk   = cfg.bsel ? quarter : third;
endmodule

module strap_clk_cfg_chk (
    input logic       clk_ref,
    input logic       por_n,
    input logic [3:0] strap_oe,
    input logic [2:0] fsel,
    input logic       bus_sync,
    input logic       test_mode,
    input logic       usb_clk,
    input logic       fd_clk,
    input logic       bus_clk
);
    p_hold_r3: assert property (@(posedge clk_ref) disable iff (!por_n)
        strap_oe[0] |=> ($stable(fsel) && $stable(bus_sync)));

    p_oe_on_r4: assert property (@(posedge clk_ref) disable iff (!por_n)
        $past(por_n) |-> (strap_oe == 4'hF));

    p_test_decode_r5: assert property (@(posedge clk_ref) disable iff (!por_n)
        test_mode |-> (fsel == 3'b011 && strap_oe[0]));

    p_half_toggle_r6: assert property (@(posedge clk_ref) disable iff (!por_n)
        (test_mode && $past(test_mode)) |-> (usb_clk != $past(usb_clk)));

    p_third_short_r9: assert property (@(posedge clk_ref) disable iff (!por_n)
        (test_mode && !bus_sync && bus_clk) |=> !bus_clk);

    p_quiet_r10: assert property (@(posedge clk_ref) disable iff (!por_n)
        !test_mode |-> (!usb_clk && !fd_clk && !bus_clk));
endmodule

bind strap_clk_cfg strap_clk_cfg_chk u_chk (
    .clk_ref   (clk_ref),
    .por_n     (por_n),
    .strap_oe  (strap_oe),
    .fsel      (fsel),
    .bus_sync  (bus_sync),
    .test_mode (test_mode),
    .usb_clk   (usb_clk),
    .fd_clk    (fd_clk),
    .bus_clk   (bus_clk)
);

// File: tb/strap_clk_cfg_tb.sv
module strap_clk_cfg_tb;
    logic       clk_ref = 1'b0;
    logic       por_n = 1'b0;
    logic [3:0] strap_in = 4'h0;
    logic       cpu_clk_in = 1'b1;
    logic [3:0] strap_out, strap_oe;
    logic [2:0] fsel;
    logic       bus_sync, test_mode, usb_clk, fd_clk, bus_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk_ref = ~clk_ref;

    strap_clk_cfg u_dut (
        .clk_ref    (clk_ref),
        .por_n      (por_n),
        .strap_in   (strap_in),
        .cpu_clk_in (cpu_clk_in),
        .strap_out  (strap_out),
        .strap_oe   (strap_oe),
        .fsel       (fsel),
        .bus_sync   (bus_sync),
        .test_mode  (test_mode),
        .usb_clk    (usb_clk),
        .fd_clk     (fd_clk),
        .bus_clk    (bus_clk)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk_ref);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int code = 0; code < 16; code++) begin
            @(negedge clk_ref);
            por_n = 1'b0;
            strap_in = code[3:0];
            repeat (2) @(posedge clk_ref);
            @(negedge clk_ref);
            // R1 reset state
            check("R1 oe", {4'h0, strap_oe}, 8'h00);
            check("R1 out", {4'h0, strap_out}, 8'h00);
            check("R1 flags", {4'h0, test_mode, usb_clk, fd_clk, bus_clk}, 8'h00);
            por_n = 1'b1;
            begin
                logic [2:0] exp_fs;
                logic       exp_bs, exp_test;
                exp_fs   = code[3:1];
                exp_bs   = code[0];
                exp_test = (exp_fs == 3'b011);
                for (int k = 0; k <= 12; k++) begin
                    logic e_usb, e_fd, e_bus;
                    @(posedge clk_ref);
                    #2;
                    if (k == 1) check("R4 high phase", {4'h0, strap_out}, 8'h0F);
                    @(negedge clk_ref);
                    e_usb = exp_test && (k % 2 == 1);
                    e_fd  = exp_test && (k % 4 >= 2);
                    e_bus = exp_test && (exp_bs ? (k % 4 >= 2) : (k % 3 == 2));
                    if (k == 0) begin
                        check("R2 fsel", {5'h0, fsel}, {5'h0, exp_fs});
                        check("R2 bus_sync", {7'h0, bus_sync}, {7'h0, exp_bs});
                        check("R4 oe", {4'h0, strap_oe}, 8'h0F);
                        check("R4 low phase", {4'h0, strap_out}, 8'h0E);
                        check("R5 test", {7'h0, test_mode}, {7'h0, exp_test});
                        strap_in = ~code[3:0];
                    end else if (k == 12) begin
                        check("R3 hold", {4'h0, bus_sync, fsel}, {4'h0, exp_bs, exp_fs});
                    end
                    if (exp_test) begin
                        check("R6 usb", {7'h0, usb_clk}, {7'h0, e_usb});
                        check("R7 fd", {7'h0, fd_clk}, {7'h0, e_fd});
                        if (exp_bs) check("R8 bus div4", {7'h0, bus_clk}, {7'h0, e_bus});
                        else        check("R9 bus div3", {7'h0, bus_clk}, {7'h0, e_bus});
                    end else begin
                        check("R10 quiet", {5'h0, usb_clk, fd_clk, bus_clk}, 8'h00);
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule